// File: doc/BRIEF.md
# Register Readiness Scoreboard with Wakeup Matrix

This block sits between rename and issue selection in an out-of-order core. It holds one ready bit for every physical register. For every occupied issue-queue slot it records which of the slot's two source operands still wait on a producer. When an instruction is written into a slot, the block checks each source against the ready bits, because an operand may have become ready while the instruction was in flight. Sources that are still pending are recorded as waiters.

When a producer completes, its destination bit is set. Every waiting source that names that register is released in the same cycle. A slot whose sources are all ready is raised on a per-slot ready vector for the selection logic. The selection logic later frees the slot through the issue port, or a flush frees it through the squash port.

Register indices at or above the physical register count stand for registers outside renaming. These indices are never tracked: as sources they count as ready, and as destinations or completions they have no effect. A new producer that targets a register which still has waiters raises an error pulse.

The insert interface is valid/ready. A beat is taken only in a cycle where `ins_valid` and `ins_ready` are both high. `ins_ready` is low while the slot named by `ins_slot` is occupied, so the sender must hold the beat or retarget it. A beat that is not taken changes nothing. Completion, issue and squash are plain one-cycle strobes.

Top module: `regwake_scoreboard`

## Requirements
- R1: After reset every register's ready bit is clear, no slot is occupied, `slot_rdy` is all zero, and `ins_ready` is high.
- R2: An accepted insert whose destination index is below NUM_PREGS clears that register's ready bit. If a completion names the same register in the same cycle, the clear wins and the bit ends up not ready.
- R3: A source whose arrival flag is low is ready if its register bit is set, or if a completion names that register in the same cycle. Otherwise it is recorded as waiting. A source whose arrival flag is high is ready regardless.
- R4: Indices greater than or equal to NUM_PREGS are never tracked. As sources they count as ready. As destinations they touch no ready bit and never raise `ovr_err`. As completions they wake nothing.
- R5: A completion of a tracked register sets its ready bit and, in that one cycle, releases every waiting source in every slot that names it.
- R6: `ovr_err` is high, in the cycle of the accepted insert, when the insert's tracked destination still has a waiting source in another slot after this cycle's wakeup and removals are taken into account.
- R7: `slot_rdy[i]` is high from the cycle after slot i holds an instruction with no waiting source. It stays high until the slot is issued or squashed.
- R8: A squash frees the slot and drops its waiting sources. It takes priority over a wakeup in the same cycle, and a later producer of a dropped register raises no `ovr_err`.
- R9: An issue strobe frees the slot, so `slot_rdy` for it falls on the next cycle.
- R10: `ins_ready` equals "slot `ins_slot` is free". A beat offered while `ins_ready` is low leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert beat valid |
| ins_ready | output | 1 | Target slot is free; beat is taken |
| ins_slot | input | SLOT_W | Queue slot to fill |
| ins_a_idx | input | TAG_W | First source register index |
| ins_a_rdy | input | 1 | First source known ready on arrival |
| ins_b_idx | input | TAG_W | Second source register index |
| ins_b_rdy | input | 1 | Second source known ready on arrival |
| ins_dst_idx | input | TAG_W | Destination index (>= NUM_PREGS means none) |
| cmp_valid | input | 1 | Producer completion strobe |
| cmp_idx | input | TAG_W | Completed destination register |
| iss_valid | input | 1 | Issue strobe, frees a slot |
| iss_slot | input | SLOT_W | Slot being issued |
| sq_valid | input | 1 | Squash strobe, frees a slot and its waiters |
| sq_slot | input | SLOT_W | Slot being squashed |
| slot_rdy | output | NUM_SLOTS | Per-slot ready-to-issue vector |
| ovr_err | output | 1 | New producer while its register still has waiters |

## Verification
The main overlap is a completion landing in the same cycle as an insert. It is provoked in two forms. In the first, a new instruction's unflagged source names the completing register, and the slot must read as ready right after that edge. In the second, a new producer targets the completing register, and a later unflagged reader must wait until a second completion. A further overlap pairs a squash with a wakeup of the squashed slot's register in one cycle; the freed slot must stay low. A scoreboard queue holds the expected ready vector for each cycle and is compared one time unit after each edge. The error pulse and `ins_ready` are compared before the edge, in the cycle that drives them.

// File: rtl/rwk_pkg.sv
package rwk_pkg;
  // sources per instruction
  localparam int NSRC = 2;
  // defaults shared by the block and its bench
  localparam int DEF_PREGS = 48;
  localparam int DEF_TAG_W = 6;
  localparam int DEF_SLOTS = 8;
endpackage

// File: rtl/rwk_ready_table.sv
module rwk_ready_table
  import rwk_pkg::*;
#(
  parameter int NUM_PREGS = DEF_PREGS,
  parameter int TAG_W     = DEF_TAG_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic [TAG_W-1:0]            set_idx,
  input  logic                        clr_en,
  input  logic [TAG_W-1:0]            clr_idx,
  input  logic [NSRC-1:0][TAG_W-1:0]  rd_idx,
  output logic [NSRC-1:0]             rd_rdy
);
  localparam logic [TAG_W:0] LIMIT = (TAG_W+1)'(NUM_PREGS);

  logic [NUM_PREGS-1:0] bits_q;
  logic set_hit, clr_hit;

  assign set_hit = set_en && ({1'b0, set_idx} < LIMIT);
  assign clr_hit = clr_en && ({1'b0, clr_idx} < LIMIT);

  // clear from a new producer has priority over a completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else begin
      for (int r = 0; r < NUM_PREGS; r++) begin
        if (clr_hit && clr_idx == TAG_W'(r))
          bits_q[r] <= 1'b0;
        else if (set_hit && set_idx == TAG_W'(r))
          bits_q[r] <= 1'b1;
      end
    end
  end

  // lookups with same-cycle completion bypass; untracked reads as ready
  for (genvar k = 0; k < NSRC; k++) begin : g_rd
    logic trk;
    assign trk = {1'b0, rd_idx[k]} < LIMIT;
    always_comb begin
      if (!trk)
        rd_rdy[k] = 1'b1;
      else
        rd_rdy[k] = bits_q[rd_idx[k]] || (set_hit && set_idx == rd_idx[k]);
    end
  end

  AST_DST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !bits_q[$past(clr_idx)]); // R2

  AST_CMP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !(clr_hit && clr_idx == set_idx)) |=> bits_q[$past(set_idx)]); // R5
endmodule

// File: rtl/rwk_slot.sv
module rwk_slot
  import rwk_pkg::*;
#(
  parameter int TAG_W = DEF_TAG_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NSRC-1:0][TAG_W-1:0]  ld_idx,
  input  logic [NSRC-1:0]             ld_wait,
  input  logic                        wake_en,
  input  logic [TAG_W-1:0]            wake_idx,
  input  logic                        kill,
  input  logic [TAG_W-1:0]            probe_idx,
  output logic                        occupied,
  output logic                        all_rdy,
  output logic                        probe_hit
);
  logic                       vld_q;
  logic [NSRC-1:0]            wait_q;
  logic [NSRC-1:0][TAG_W-1:0] tag_q;
  logic [NSRC-1:0]            wake_hit;
  logic [NSRC-1:0]            probe_match;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign wake_hit[k]    = wake_en && (tag_q[k] == wake_idx);
    assign probe_match[k] = wait_q[k] && (tag_q[k] == probe_idx);

    AST_WAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q[k] && wake_hit[k] && !kill && !load) |=> !wait_q[k]); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wait_q <= '0;
      tag_q  <= '0;
    end else if (kill) begin
      vld_q  <= 1'b0;
      wait_q <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      wait_q <= ld_wait;
      tag_q  <= ld_idx;
    end else begin
      wait_q <= wait_q & ~wake_hit;
    end
  end

  assign occupied  = vld_q;
  assign all_rdy   = vld_q && (wait_q == '0);
  // a waiter survives this cycle unless freed or woken on the probed register
  assign probe_hit = vld_q && !kill && (|probe_match) &&
                     !(wake_en && wake_idx == probe_idx);

  AST_KILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!occupied && !all_rdy)); // R8

  AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (all_rdy && !kill) |=> all_rdy); // R7
endmodule

// File: rtl/regwake_scoreboard.sv
module regwake_scoreboard
  import rwk_pkg::*;
#(
  parameter int NUM_PREGS = DEF_PREGS,
  parameter int TAG_W     = DEF_TAG_W,
  parameter int NUM_SLOTS = DEF_SLOTS,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  output logic                 ins_ready,
  input  logic [SLOT_W-1:0]    ins_slot,
  input  logic [TAG_W-1:0]     ins_a_idx,
  input  logic                 ins_a_rdy,
  input  logic [TAG_W-1:0]     ins_b_idx,
  input  logic                 ins_b_rdy,
  input  logic [TAG_W-1:0]     ins_dst_idx,
  input  logic                 cmp_valid,
  input  logic [TAG_W-1:0]     cmp_idx,
  input  logic                 iss_valid,
  input  logic [SLOT_W-1:0]    iss_slot,
  input  logic                 sq_valid,
  input  logic [SLOT_W-1:0]    sq_slot,
  output logic [NUM_SLOTS-1:0] slot_rdy,
  output logic                 ovr_err
);
  localparam logic [TAG_W:0] LIMIT = (TAG_W+1)'(NUM_PREGS);

  logic                       ins_fire;
  logic                       dst_trk;
  logic                       cmp_trk;
  logic [NSRC-1:0][TAG_W-1:0] src_idx;
  logic [NSRC-1:0]            src_flag;
  logic [NSRC-1:0]            tbl_rdy;
  logic [NSRC-1:0]            src_wait;
  logic [NUM_SLOTS-1:0]       occ;
  logic [NUM_SLOTS-1:0]       hits;

  assign src_idx  = {ins_b_idx, ins_a_idx};
  assign src_flag = {ins_b_rdy, ins_a_rdy};
  assign ins_ready = !occ[ins_slot];
  assign ins_fire  = ins_valid && ins_ready;
  assign dst_trk   = {1'b0, ins_dst_idx} < LIMIT;
  assign cmp_trk   = cmp_valid && ({1'b0, cmp_idx} < LIMIT);
  assign src_wait  = ~(src_flag | tbl_rdy);

  rwk_ready_table #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (cmp_valid),
    .set_idx (cmp_idx),
    .clr_en  (ins_fire),
    .clr_idx (ins_dst_idx),
    .rd_idx  (src_idx),
    .rd_rdy  (tbl_rdy)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic load_s, kill_s;
    assign load_s = ins_fire && (ins_slot == SLOT_W'(s));
    assign kill_s = (iss_valid && iss_slot == SLOT_W'(s)) ||
                    (sq_valid  && sq_slot  == SLOT_W'(s));

    rwk_slot #(.TAG_W(TAG_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_s),
      .ld_idx    (src_idx),
      .ld_wait   (src_wait),
      .wake_en   (cmp_trk),
      .wake_idx  (cmp_idx),
      .kill      (kill_s),
      .probe_idx (ins_dst_idx),
      .occupied  (occ[s]),
      .all_rdy   (slot_rdy[s]),
      .probe_hit (hits[s])
    );
  end

  assign ovr_err = ins_fire && dst_trk && (|hits);

  AST_ERR_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> ({1'b0, ins_dst_idx} < LIMIT)); // R4

  AST_FIRE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && !(iss_valid && iss_slot == ins_slot) && !(sq_valid && sq_slot == ins_slot))
      |=> occ[$past(ins_slot)]); // R10
endmodule

// File: tb/regwake_scoreboard_bench.sv
module regwake_scoreboard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ins_valid = 0, ins_a_rdy = 0, ins_b_rdy = 0;
  logic [2:0] ins_slot = '0, iss_slot = '0, sq_slot = '0;
  logic [5:0] ins_a_idx = '0, ins_b_idx = '0, ins_dst_idx = '0, cmp_idx = '0;
  logic       cmp_valid = 0, iss_valid = 0, sq_valid = 0;
  logic       ins_ready, ovr_err;
  logic [7:0] slot_rdy;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] qv[$];
  string      qt[$];

  always #2 clk = ~clk;

  regwake_scoreboard u_regwake_scoreboard (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_slot(ins_slot), .ins_a_idx(ins_a_idx), .ins_a_rdy(ins_a_rdy),
    .ins_b_idx(ins_b_idx), .ins_b_rdy(ins_b_rdy), .ins_dst_idx(ins_dst_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .iss_valid(iss_valid),
    .iss_slot(iss_slot), .sq_valid(sq_valid), .sq_slot(sq_slot),
    .slot_rdy(slot_rdy), .ovr_err(ovr_err)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected ready vector one unit after each edge
  always @(posedge clk) begin
    #1;
    if (qv.size() > 0) check(slot_rdy, qv.pop_front(), qt.pop_front());
  end

  task automatic put(input logic [2:0] s, input logic [5:0] a, input logic ar,
                     input logic [5:0] b, input logic br, input logic [5:0] d);
    ins_valid = 1; ins_slot = s; ins_a_idx = a; ins_a_rdy = ar;
    ins_b_idx = b; ins_b_rdy = br; ins_dst_idx = d;
  endtask

  // driver: checks pre-edge outputs, queues the post-edge expectation
  task automatic tick(input logic [7:0] exp_rdy, input logic exp_err,
                      input logic exp_irdy, input string tag);
    #1;
    check({7'b0, ovr_err}, {7'b0, exp_err}, {tag, " err"});
    if (ins_valid) check({7'b0, ins_ready}, {7'b0, exp_irdy}, {tag, " ins_ready"});
    qv.push_back(exp_rdy); qt.push_back({tag, " slot_rdy"});
    @(posedge clk); @(negedge clk);
    ins_valid = 0; cmp_valid = 0; iss_valid = 0; sq_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(slot_rdy, 8'h00, "R1 reset slot_rdy");
    check({7'b0, ins_ready}, 8'h01, "R1 reset ins_ready");
    @(negedge clk);
    // R1 bit clear on reset; R4 untracked source counts ready
    put(0, 6'd3, 0, 6'd60, 0, 6'd63);                 tick(8'h00, 0, 1, "R1 R4 r3 waits");
    put(1, 6'd3, 1, 6'd5, 1, 6'd10);                  tick(8'h02, 0, 1, "R7 flagged ready");
    cmp_valid = 1; cmp_idx = 6'd3;                    tick(8'h03, 0, 1, "R5 wake r3");
    put(2, 6'd3, 0, 6'd10, 0, 6'd63);                 tick(8'h03, 0, 1, "R3 scoreboard lookup");
    put(3, 6'd62, 1, 6'd62, 1, 6'd10);                tick(8'h0B, 1, 1, "R6 producer over waiter");
    put(4, 6'd10, 0, 6'd3, 1, 6'd63);
    cmp_valid = 1; cmp_idx = 6'd10;                   tick(8'h1F, 0, 1, "R3 R5 bypass and wake");
    put(5, 6'd1, 1, 6'd1, 1, 6'd3);                   tick(8'h3F, 0, 1, "R2 new producer r3");
    put(6, 6'd3, 0, 6'd1, 1, 6'd63);                  tick(8'h3F, 0, 1, "R2 r3 now not ready");
    sq_valid = 1; sq_slot = 6;                        tick(8'h3F, 0, 1, "R8 squash waiter");
    put(7, 6'd1, 1, 6'd1, 1, 6'd3);                   tick(8'hBF, 0, 1, "R8 no err after squash");
    iss_valid = 1; iss_slot = 0;                      tick(8'hBE, 0, 1, "R9 issue frees");
    put(0, 6'd3, 0, 6'd3, 0, 6'd63);                  tick(8'hBE, 0, 1, "R3 waits on r3");
    put(1, 6'd9, 0, 6'd9, 0, 6'd20);                  tick(8'hBE, 0, 0, "R10 blocked beat");
    cmp_valid = 1; cmp_idx = 6'd50;                   tick(8'hBE, 0, 1, "R4 untracked completion");
    put(6, 6'd1, 1, 6'd1, 1, 6'd55);                  tick(8'hFE, 0, 1, "R4 untracked dst");
    cmp_valid = 1; cmp_idx = 6'd3;
    sq_valid = 1; sq_slot = 0;                        tick(8'hFE, 0, 1, "R8 squash beats wake");
    put(0, 6'd3, 0, 6'd3, 0, 6'd63);                  tick(8'hFF, 0, 1, "R5 bit set by completion");
    iss_valid = 1; iss_slot = 6;                      tick(8'hBF, 0, 1, "R9 issue slot6");
    put(6, 6'd1, 1, 6'd1, 1, 6'd7);
    cmp_valid = 1; cmp_idx = 6'd7;                    tick(8'hFF, 0, 1, "R2 clear vs set");
    iss_valid = 1; iss_slot = 1;                      tick(8'hFD, 0, 1, "R9 issue slot1");
    put(1, 6'd7, 0, 6'd40, 1, 6'd63);                 tick(8'hFD, 0, 1, "R2 clear won");
    cmp_valid = 1; cmp_idx = 6'd7;                    tick(8'hFF, 0, 1, "R5 wake r7");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule